// File: doc/BRIEF.md
# Posted-Write Buffer with Read Forwarding

This block sits between a command source and a single-port synchronous storage array and turns every write into a posted, late write. A write command carries only its address; its data arrives on a separate input one clock later. The address and data are parked in a one-entry holding buffer. They reach the array only when the following write has its own data in hand, so the array sees at most one write per write operation and never a write whose data is still missing.

Reads are issued on the same command port and return their word on a registered output one clock after the read address is registered. Whenever the read address equals the address parked in the buffer, the returned word is taken from the buffer rather than from the array. Because the buffer is loaded on the same edge that registers a read, a read issued in the data cycle of a write to the same address already returns the new word. The array write port is also brought out, so the surrounding logic can see exactly which address and word are committed, and when.

Top module: `latewr_buf`

## Requirements
- R1: After reset rd_valid is 0 and the holding buffer is empty, so the data cycle of the first write after reset drives no array write (arr_we stays 0).
- R2: arr_we is 1 only in the cycle after a write command (its data cycle), and only when an earlier write is parked; arr_addr and arr_wdata then carry that earlier write's address and data.
- R3: Write data is taken from wr_data only in the data cycle; a value on wr_data in any other cycle has no effect on what later reads return.
- R4: A read command registered at one rising edge gives rd_valid = 1 with its word on rd_data for exactly the clock cycle that follows the next rising edge.
- R5: A read of the address parked in the buffer returns the parked word, even though the array does not hold it yet.
- R6: A read issued in the data cycle of a write to the same address returns the data presented on wr_data in that cycle.
- R7: A read whose address differs from the parked address returns the word most recently committed to the array at that address.
- R8: With back-to-back write commands, each data cycle commits exactly the write issued two cycles earlier, with the data presented one cycle earlier.
- R9: A cycle with cmd_valid = 0 that is not a data cycle causes no array write and no rd_valid pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_addr | input | AW | Command address |
| wr_data | input | DW | Write data, sampled in the cycle after a write command |
| rd_valid | output | 1 | Read word valid on rd_data |
| rd_data | output | DW | Registered read word |
| arr_we | output | 1 | Array write strobe for the parked write |
| arr_addr | output | AW | Address being committed to the array |
| arr_wdata | output | DW | Word being committed to the array |

## Verification
The main function is driven first with a long run of back-to-back writes that fill every address, which separates a commit of the immediately preceding write from a commit that skips or repeats one. Reads are then mixed in at three distances from a write to the same address: in its data cycle, while it is still parked, and after a later write has pushed it into the array, so that forwarding from the buffer is told apart from reading the array. Idle cycles carrying junk on the write-data input, and a reset in the middle of the run, show that data is sampled only in data cycles and that an emptied buffer commits nothing.

// File: rtl/latewr_buf.sv
`timescale 1ns/1ps
module latewr_buf #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] wr_data,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          wa_v;
  logic [AW-1:0] wa_addr;
  logic          pk_v;
  logic [AW-1:0] pk_addr;
  logic [DW-1:0] pk_data;
  logic          ra_v;
  logic [AW-1:0] ra_addr;
  logic          fwd_hit;
  logic [DW-1:0] rd_next;

  assign arr_we    = wa_v & pk_v;
  assign arr_addr  = pk_addr;
  assign arr_wdata = pk_data;

  assign fwd_hit = pk_v && (pk_addr == ra_addr);
  assign rd_next = fwd_hit ? pk_data : mem[ra_addr];

  always_ff @(posedge clk) begin
    if (arr_we) mem[arr_addr] <= arr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa_v     <= 1'b0;
      wa_addr  <= '0;
      pk_v     <= 1'b0;
      pk_addr  <= '0;
      pk_data  <= '0;
      ra_v     <= 1'b0;
      ra_addr  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      wa_v    <= cmd_valid & cmd_write;
      wa_addr <= cmd_addr;
      if (wa_v) begin
        pk_v    <= 1'b1;
        pk_addr <= wa_addr;
        pk_data <= wr_data;
      end
      ra_v     <= cmd_valid & ~cmd_write;
      ra_addr  <= cmd_addr;
      rd_valid <= ra_v;
      if (ra_v) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/latewr_buf_chk.sv
`timescale 1ns/1ps
module latewr_buf_chk #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_write,
  input logic [AW-1:0] cmd_addr,
  input logic [DW-1:0] wr_data,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          arr_we,
  input logic [AW-1:0] arr_addr,
  input logic [DW-1:0] arr_wdata
);
  logic       is_wr;
  logic       is_rd;
  logic [1:0] ck_nwr;

  assign is_wr = cmd_valid && cmd_write;
  assign is_rd = cmd_valid && !cmd_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_nwr <= 2'd0;
    else if (is_wr && ck_nwr != 2'd2) ck_nwr <= ck_nwr + 2'd1;
  end

  a_r1_first_write_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_wr) |-> (arr_we == (ck_nwr == 2'd2)));

  a_r2_we_only_in_data_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> $past(is_wr));

  a_r4_read_returns_in_two: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> ##1 rd_valid);

  a_r4_valid_has_a_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(is_rd, 2));

  a_r6_same_cycle_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(is_wr, 3) && ($past(cmd_addr, 3) == $past(cmd_addr, 2)))
      |-> (rd_data == $past(wr_data, 2)));

  a_r8_back_to_back_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(is_wr, 2))
      |-> (arr_addr == $past(cmd_addr, 2) && arr_wdata == $past(wr_data, 1)));
endmodule

bind latewr_buf latewr_buf_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .cmd_addr(cmd_addr), .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
  .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
);

// File: tb/latewr_buf_tb.sv
`timescale 1ns/1ps
module latewr_buf_tb;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam logic [1:0] OP_N = 2'd0, OP_R = 2'd1, OP_W = 2'd2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          arr_we;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;

  always #10 clk = ~clk;

  latewr_buf #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference: writes land in ref_mem in their data cycle
  logic [DW-1:0] ref_mem [16];
  logic          m_wpend, m_bvalid, m_b2b;
  logic [AW-1:0] m_waddr, m_baddr;
  logic [DW-1:0] m_bdata;
  logic          p_v, q_v;
  logic [DW-1:0] p_d, q_d;
  logic [3:0]    p_t, q_t;

  // {op, addr, data, requirement tag of the read}
  localparam int NV = 20;
  localparam logic [25:0] VEC [NV] = '{
    {OP_W, 4'h3, 16'h100F, 4'd8},
    {OP_R, 4'h3, 16'hA5A3, 4'd6},  // R6 read in data cycle of same address
    {OP_N, 4'h0, 16'hDEAD, 4'd9},  // R3 junk outside a data cycle
    {OP_R, 4'h3, 16'h0000, 4'd3},  // R3 / R5 parked word, junk ignored
    {OP_R, 4'h5, 16'h0000, 4'd7},  // R7 array word
    {OP_W, 4'h7, 16'h0000, 4'd2},
    {OP_R, 4'h9, 16'h1111, 4'd7},
    {OP_W, 4'h7, 16'h0000, 4'd2},
    {OP_W, 4'h3, 16'h2222, 4'd8},
    {OP_R, 4'h7, 16'h3333, 4'd7},
    {OP_R, 4'h3, 16'h0000, 4'd5},  // R5 forwarded from buffer
    {OP_N, 4'h0, 16'hBEEF, 4'd9},
    {OP_N, 4'h0, 16'hBEEF, 4'd9},
    {OP_R, 4'h7, 16'h0000, 4'd3},
    {OP_W, 4'hF, 16'h0000, 4'd2},
    {OP_N, 4'h0, 16'h4444, 4'd2},
    {OP_R, 4'hF, 16'h0000, 4'd5},
    {OP_R, 4'h0, 16'h0000, 4'd7},
    {OP_N, 4'h0, 16'h0000, 4'd9},
    {OP_N, 4'h0, 16'h0000, 4'd9}
  };

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_wpend = 0; m_bvalid = 0; m_b2b = 0;
    m_waddr = '0; m_baddr = '0; m_bdata = '0;
    p_v = 0; q_v = 0; p_d = '0; q_d = '0; p_t = '0; q_t = '0;
  endtask

  task automatic step(input logic [1:0] op, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [3:0] t);
    logic  exp_we;
    string twe;
    @(negedge clk);
    cmd_valid = (op != OP_N);
    cmd_write = (op == OP_W);
    cmd_addr  = a;
    wr_data   = d;
    #2;
    exp_we = m_wpend && m_bvalid;
    if (exp_we)       twe = m_b2b ? "R8" : "R2";
    else if (m_wpend) twe = "R1";
    else if (op == OP_N) twe = "R9";
    else twe = "R2";
    chk(twe, "arr_we", DW'(arr_we), DW'(exp_we));
    if (exp_we) begin
      chk(twe, "arr_addr", DW'(arr_addr), DW'(m_baddr));
      chk(twe, "arr_wdata", arr_wdata, m_bdata);
    end
    chk(q_v ? "R4" : "R9", "rd_valid", DW'(rd_valid), DW'(q_v));
    if (q_v) chk($sformatf("R%0d", q_t), "rd_data", rd_data, q_d);
    // end-of-cycle model update
    q_v = p_v; q_d = p_d; q_t = p_t;
    m_b2b = m_wpend;
    if (m_wpend) begin
      ref_mem[m_waddr] = d;
      m_bvalid = 1; m_baddr = m_waddr; m_bdata = d;
    end
    m_wpend = (op == OP_W);
    m_waddr = a;
    p_v = (op == OP_R);
    p_d = ref_mem[a];
    p_t = t;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cmd_valid = 0; cmd_write = 0;
    model_reset();
    @(negedge clk);
    chk("R1", "rd_valid in reset", DW'(rd_valid), '0);
    chk("R1", "arr_we in reset", DW'(arr_we), '0);
    rst_n = 1;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ref_mem[i] = '0;
    model_reset();
    repeat (3) @(negedge clk);
    do_reset();
    // R8 fill every address with back-to-back writes
    for (int i = 0; i < 16; i++)
      step(OP_W, AW'(i), (i == 0) ? 16'h0000 : 16'h1000 + DW'(i - 1), 4'd8);
    for (int k = 0; k < NV; k++)
      step(VEC[k][25:24], VEC[k][23:20], VEC[k][19:4], VEC[k][3:0]);
    // R1 reset mid-run empties the buffer
    do_reset();
    step(OP_W, 4'h2, 16'h0000, 4'd1);
    step(OP_N, 4'h0, 16'h5555, 4'd1);
    step(OP_R, 4'h2, 16'h0000, 4'd5);
    step(OP_R, 4'h6, 16'h0000, 4'd7);
    step(OP_N, 4'h0, 16'h0000, 4'd9);
    step(OP_N, 4'h0, 16'h0000, 4'd9);
    step(OP_N, 4'h0, 16'h0000, 4'd9);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule